// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a stereo PCM stream from a three-wire serial link and turns it into parallel sample words. The link consists of a bit clock, a word clock and a data line. The bit clock, word clock and data line are oversampled by the block's own system clock. Serial bits are taken on rising edges of the bit clock. Each word arrives most-significant bit first in two's complement. The word clock marks both which channel is being sent and where each word begins.

Two static configuration inputs set how the stream is read:

- **Frame alignment.** In I2S alignment, the MSB follows the word-clock change after a one-bit delay. In LSB-justified alignment, the word ends on the last bit before the word-clock change.
- **Word length.** Each word is either 16 or 18 bits long.

Completed left and right words are presented together as sign-extended 18-bit values, along with a one-cycle strobe. A run qualifier holds the receiver idle after reset until the word clock first falls.

Top module: `audio_ser_rx`

## Requirements
- R1: Data is taken only at bit-clock rising edges. A change on the data line while the bit clock is high does not alter the received sample.
- R2: With `len18_i`=1, each word is 18 bits, MSB first, two's complement, and is output unchanged.
- R3: With `len18_i`=0, each word is 16 bits. Bit 15 is copied into output bits 17:16.
- R4: With `lsbj_i`=0 (I2S), the word-clock level seen at the previous bit-clock rise names the channel of the current bit, with 0 meaning left and 1 meaning right. As a result, the MSB arrives on the second rise after a word-clock change.
- R5: With `lsbj_i`=1 (LSB-justified), the word-clock level at the current rise names the channel, with 0 meaning left. The word is the final N bits before the word clock changes.
- R6: Bits of a half-frame that lie beyond the configured word length are ignored. In I2S these are the bits after the LSB; in LSB-justified they are the bits before the MSB.
- R7: After reset, `run_o` stays 0 and no sample is output until the first falling edge of the word clock. From then on, `run_o` stays 1 until the next reset.
- R8: `valid_o` is a single-cycle pulse, given once per stereo frame. `left_o` and `right_o` change only in that cycle and carry the words of the same frame.
- R9: `valid_o` rises on the third system-clock edge after the bit-clock rise that carries the first bit tagged left following a right word.
- R10: An asynchronous low level on `rst_ni` clears `left_o`, `right_o`, `valid_o` and `run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock, 0 = left, 1 = right |
| sdata_i | input | 1 | Serial data |
| lsbj_i | input | 1 | 0 = I2S alignment, 1 = LSB-justified |
| len18_i | input | 1 | 0 = 16-bit words, 1 = 18-bit words |
| left_o | output | 18 | Left sample, sign-extended |
| right_o | output | 18 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when a stereo pair is presented |
| run_o | output | 1 | High once the first word-clock fall after reset has been seen |

## Verification
Each link line passes through two synchroniser flops and one edge stage, so every result lands on the third system-clock edge after the link event that causes it. This applies both to the sample pair with its strobe and to `run_o` after a word-clock fall. The bench drives the link one bit slot at a time, with four system cycles per slot, and samples on falling system-clock edges. Most results are checked a full slot or more after they are due. For the latency requirement, two frames are probed cycle by cycle: the strobe is checked low after the second edge, high after the third and low again after the fourth.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  localparam int unsigned LONG_W  = 18;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned CNT_W   = $clog2(LONG_W + 1);

  typedef enum logic {FMT_I2S = 1'b0, FMT_LSBJ = 1'b1} fmt_e;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
  typedef logic [LONG_W-1:0] sample_t;
endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/asrx_frame.sv
module asrx_frame
  import asrx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_rise_i,
  input  logic ws_fall_i,
  input  logic ws_i,
  input  fmt_e fmt_i,
  output logic run_o,
  output logic bit_en_o,
  output logic word_start_o,
  output logic done_left_o,
  output logic done_right_o
);
  logic  ws_at_rise_q;
  logic  run_q;
  logic  armed_q;
  chan_e last_tag_q;
  chan_e tag;

  // I2S data lags the word clock by one bit
  assign tag = (fmt_i == FMT_LSBJ) ? chan_e'(ws_i) : chan_e'(ws_at_rise_q);

  assign bit_en_o     = bit_rise_i && run_q;
  assign word_start_o = bit_en_o && (tag != last_tag_q);
  assign done_left_o  = word_start_o && armed_q && (last_tag_q == CH_LEFT);
  assign done_right_o = word_start_o && armed_q && (last_tag_q == CH_RIGHT);
  assign run_o        = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_at_rise_q <= 1'b0;
      run_q        <= 1'b0;
      armed_q      <= 1'b0;
      last_tag_q   <= CH_RIGHT;
    end else begin
      if (bit_rise_i) ws_at_rise_q <= ws_i;
      if (ws_fall_i)  run_q <= 1'b1;
      if (bit_en_o) begin
        last_tag_q <= tag;
        // first boundary only aligns; the word before it is partial
        if (word_start_o) armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/asrx_word.sv
module asrx_word
  import asrx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bit_en_i,
  input  logic    word_start_i,
  input  logic    sd_i,
  input  fmt_e    fmt_i,
  input  logic    len18_i,
  output sample_t word_o
);
  sample_t          shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] n_bits;
  logic             take;

  assign n_bits = len18_i ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
  // I2S keeps the leading N bits, LSB-justified keeps the trailing N
  assign take   = (fmt_i == FMT_LSBJ) || (cnt_q < n_bits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (bit_en_i) begin
      if (word_start_i) begin
        shift_q <= {{(LONG_W-1){1'b0}}, sd_i};
        cnt_q   <= CNT_W'(1);
      end else begin
        if (take) shift_q <= {shift_q[LONG_W-2:0], sd_i};
        if (cnt_q < CNT_W'(LONG_W)) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign word_o = len18_i ? shift_q
                          : {{(LONG_W-SHORT_W){shift_q[SHORT_W-1]}}, shift_q[SHORT_W-1:0]};
endmodule

// File: rtl/audio_ser_rx.sv
module audio_ser_rx
  import asrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic              lsbj_i,
  input  logic              len18_i,
  output logic [LONG_W-1:0] left_o,
  output logic [LONG_W-1:0] right_o,
  output logic              valid_o,
  output logic              run_o
);
  localparam int unsigned LINES = 3;

  logic [LINES-1:0] line_s;
  logic             bclk_s, wclk_s, sd_s;
  logic             bclk_d, wclk_d;
  logic             bit_rise, ws_fall;
  logic             bit_en, word_start, done_left, done_right;
  fmt_e             fmt;
  sample_t          word;
  sample_t          left_hold_q;

  assign fmt = fmt_e'(lsbj_i);

  asrx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdata_i, wclk_i, bclk_i}),
    .q_o    (line_s)
  );

  assign {sd_s, wclk_s, bclk_s} = line_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d <= 1'b0;
      wclk_d <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      wclk_d <= wclk_s;
    end
  end

  assign bit_rise = bclk_s & ~bclk_d;
  assign ws_fall  = wclk_d & ~wclk_s;

  asrx_frame i_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_rise_i   (bit_rise),
    .ws_fall_i    (ws_fall),
    .ws_i         (wclk_s),
    .fmt_i        (fmt),
    .run_o        (run_o),
    .bit_en_o     (bit_en),
    .word_start_o (word_start),
    .done_left_o  (done_left),
    .done_right_o (done_right)
  );

  asrx_word i_word (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en),
    .word_start_i (word_start),
    .sd_i         (sd_s),
    .fmt_i        (fmt),
    .len18_i      (len18_i),
    .word_o       (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= done_right;
      if (done_left) left_hold_q <= word;
      if (done_right) begin
        left_o  <= left_hold_q;
        right_o <= word;
      end
    end
  end
endmodule

// File: rtl/audio_ser_rx_chk.sv
module audio_ser_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        len18_i,
  input logic [17:0] left_o,
  input logic [17:0] right_o,
  input logic        valid_o,
  input logic        run_o
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

  // R7
  valid_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> run_o);

  // R7
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);

  // R3
  sign_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !len18_i) |->
      (left_o[17:16] == {2{left_o[15]}}) && (right_o[17:16] == {2{right_o[15]}}));
endmodule

bind audio_ser_rx audio_ser_rx_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .len18_i (len18_i),
  .left_o  (left_o),
  .right_o (right_o),
  .valid_o (valid_o),
  .run_o   (run_o)
);

// File: tb/test_audio_ser_rx.sv
module test_audio_ser_rx;
  localparam int HALF = 24;
  localparam int NV   = 8;

  typedef struct packed {
    logic        lsbj;
    logic        len18;
    logic [17:0] l;
    logic [17:0] r;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 18'h1FFFF, 18'h20000},
    '{1'b0, 1'b1, 18'h2A5C3, 18'h15A3C},
    '{1'b0, 1'b0, 18'h08000, 18'h07FFF},
    '{1'b0, 1'b0, 18'h3FFFF, 18'h00001},
    '{1'b1, 1'b1, 18'h20001, 18'h1FFFE},
    '{1'b1, 1'b1, 18'h00000, 18'h3FFFF},
    '{1'b1, 1'b0, 18'h0ABCD, 18'h05432},
    '{1'b1, 1'b0, 18'h37FFF, 18'h0C001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b1, sd = 1'b0, lsbj = 1'b0, len18 = 1'b1;
  logic [17:0] left_o, right_o;
  logic valid_o, run_o;

  int tests = 0, fails = 0, nvalid = 0;
  logic [17:0] got_l = '0, got_r = '0;
  logic carry = 1'b1;

  always #2.5 clk = ~clk;

  audio_ser_rx i_audio_ser_rx (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sd),
    .lsbj_i(lsbj), .len18_i(len18), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .run_o(run_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      nvalid = nvalid + 1;
      got_l  = left_o;
      got_r  = right_o;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] expect_w(input logic [17:0] w, input logic l18);
    return l18 ? w : {{2{w[15]}}, w[15:0]};
  endfunction

  // bit at position q of one channel's half-frame, pads are 1
  function automatic logic bit_of(input logic fm, input logic l18, input logic [17:0] w, input int q);
    int n = l18 ? 18 : 16;
    if (!fm) return (q < n) ? w[n-1-q] : 1'b1;
    return (q >= HALF - n) ? w[HALF-1-q] : 1'b1;
  endfunction

  task automatic slot(input logic w, input logic b, input logic probe);
    @(negedge clk); bclk = 1'b0; wclk = w; sd = b;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk); sd = ~b;   // R1: toggle while bit clock is high
    if (probe) begin
      @(negedge clk); check(valid_o == 1'b0, "R9 early", 32'(valid_o), 32'd0);
      @(negedge clk); check(valid_o == 1'b1, "R9 due",   32'(valid_o), 32'd1);
      @(negedge clk); check(valid_o == 1'b0, "R9 late",  32'(valid_o), 32'd0);
    end
  endtask

  task automatic send_half(input logic fm, input logic l18, input logic ch,
                           input logic [17:0] w, input int probe_slot);
    for (int s = 0; s < HALF; s++) begin
      logic b;
      if (fm) b = bit_of(fm, l18, w, s);
      else    b = (s == 0) ? carry : bit_of(fm, l18, w, s - 1);
      slot(ch, b, s == probe_slot);
    end
    if (!fm) carry = bit_of(fm, l18, w, HALF - 1);
  endtask

  task automatic do_reset(input logic fm, input logic l18);
    @(negedge clk); rst_n = 1'b0; bclk = 1'b0; wclk = 1'b1; sd = 1'b0;
    lsbj = fm; len18 = l18;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nvalid = 0;
    carry = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check({left_o, right_o, valid_o, run_o} == '0, "R10 reset state",
          32'({valid_o, run_o, left_o[13:0]}), 32'd0);

    // R7: traffic before the first word-clock fall is ignored
    do_reset(1'b1, 1'b1);
    for (int s = 0; s < 30; s++) slot(1'b1, s[0], 1'b0);
    check(run_o == 1'b0, "R7 no run before fall", 32'(run_o), 32'd0);
    check(nvalid == 0, "R7 no strobe before run", 32'(nvalid), 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [17:0] el = expect_w(v.l, v.len18);
      logic [17:0] er = expect_w(v.r, v.len18);
      int probe = (i == 1 || i == 5) ? (v.lsbj ? 0 : 1) : -1;
      do_reset(v.lsbj, v.len18);
      slot(1'b1, 1'b0, 1'b0);
      slot(1'b1, 1'b0, 1'b0);
      check(run_o == 1'b0, "R7 idle", 32'(run_o), 32'd0);
      send_half(v.lsbj, v.len18, 1'b0, v.l, -1);
      check(run_o == 1'b1, "R7 run after fall", 32'(run_o), 32'd1);
      send_half(v.lsbj, v.len18, 1'b1, v.r, -1);
      send_half(v.lsbj, v.len18, 1'b0, 18'h0, probe);
      send_half(v.lsbj, v.len18, 1'b1, 18'h0, -1);
      check(nvalid == 1, "R8 one strobe per frame", 32'(nvalid), 32'd1);
      check(got_l == el, v.lsbj ? "R5 R6 left" : "R4 R6 left", 32'(got_l), 32'(el));
      check(got_r == er, v.len18 ? "R2 R1 right" : "R3 R1 right", 32'(got_r), 32'(er));
    end

    // R10: asynchronous clear mid-operation
    @(negedge clk); rst_n = 1'b0;
    #1;
    check({left_o, right_o, valid_o, run_o} == '0, "R10 async clear",
          32'({run_o, left_o[13:0]}), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule